// File: doc/BRIEF.md
# End-of-Process Pin Controller

This block owns a single active-low end-of-process / terminal-count pin that is shared with DMA slave devices. At the moment a channel starts to be served, the pin is given one of three jobs. In listen mode the controller stops driving the pin and watches it, so that a slave can end the transfer. In count mode it drives the pin low after the last transfer of a byte count. In interrupt mode it reflects the buffer-expired interrupt of the channel that is being served. Whenever no channel is in use, and after reset, the pin is driven and held high (negated).

The pin is sampled through a short synchronizer, because a slave can assert it at any time. A slave assertion seen in listen mode produces a one-cycle `term_pulse` for the transfer engine. It also raises `addr_float`, which asks for the address bus to be released, and `addr_float` stays high until the channel is no longer busy.

In count mode the pin stays low until address enable drops. The exception is an autoinitialize strobe, which lets the pin go before address enable falls. The interrupt mirror is a register clocked on the falling clock edge, so the pin follows the interrupt half a cycle after it changes.

The controller is one state machine.
- States:
  - `ST_IDLE`: no channel in use.
  - `ST_SENSE`: listening to the pin.
  - `ST_HALT`: a slave has ended the transfer and the address is released.
  - `ST_TC_ARM`: count mode, waiting for the last transfer.
  - `ST_TC_ON`: pin driven low.
  - `ST_TC_REL`: released early by autoinitialize.
  - `ST_IRQ`: interrupt mirror.
- Transitions:
  - From any state to `ST_IDLE` when `ch_busy` is low.
  - From `ST_IDLE` to the state of the mode when `ch_busy` is high.
  - `ST_SENSE` to `ST_HALT` on a synchronized slave assertion.
  - `ST_TC_ARM` to `ST_TC_ON` on `addr_stb` together with `cnt_done`.
  - `ST_TC_ON` to `ST_TC_ARM` on `aen` low.
  - `ST_TC_ON` to `ST_TC_REL` on `autoinit_stb`.
  - `ST_TC_REL` to `ST_TC_ARM` on `aen` low.

Top module: `eop_pin_ctrl`

## Requirements
- R1: During and right after reset, `pin_out`=1, `pin_oe`=1, `term_pulse`=0 and `addr_float`=0.
- R2: While the FSM is idle (after any edge that samples `ch_busy` low), the pin is driven (`pin_oe`=1) and negated (`pin_out`=1), whatever the interrupt and count inputs are.
- R3: `mode_sel` is taken only at the edge where an idle controller sees `ch_busy` high. The encodings are 0 = listen, 1 = count, 2 = interrupt, and 3 = quiet, where the FSM stays idle and the pin stays negated. A change of `mode_sel` while a channel is busy has no effect.
- R4: In listen mode `pin_oe` is 0 from the edge that starts the channel until the edge that samples `ch_busy` low.
- R5: In listen mode, a low level on `pin_in` gives `term_pulse`=1 for exactly one cycle, which follows the second clock edge that samples that low level. `addr_float` rises with that pulse and stays high until the channel ends. No later pin activity produces another pulse.
- R6: In count mode, `pin_out` goes to 0 in the cycle after an edge that samples `addr_stb`=1 with `cnt_done`=1. `addr_stb` without `cnt_done` does not assert it.
- R7: Once asserted in count mode, `pin_out` stays 0 until the edge that samples `aen`=0, and is 1 from the cycle that follows.
- R8: An `autoinit_stb` sampled while the count output is asserted releases it in the next cycle, even though `aen` is still 1. No new assertion can happen until `aen` has been sampled low.
- R9: In interrupt mode, `pin_out` is the inverse of `ch_irq[act_ch]`, updated on the falling clock edge.
- R10: In interrupt mode, the interrupt bits of channels other than `act_ch` have no effect on `pin_out`.
- R11: From any state, an edge that samples `ch_busy`=0 returns the pin to driven and negated in the following cycle, and clears `addr_float`.
- R12: `term_pulse` is never raised outside listen mode, even when `pin_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Pin job: 0 listen, 1 count, 2 interrupt, 3 quiet |
| ch_busy | input | 1 | A channel is being served |
| aen | input | 1 | Address enable, high while the DMA owns the address bus |
| addr_stb | input | 1 | A new address was driven this cycle |
| cnt_done | input | 1 | The byte count expires with this transfer |
| autoinit_stb | input | 1 | An autoinitialize cycle is starting |
| ch_irq | input | NUM_CH | Per-channel buffer-expired interrupt flags |
| act_ch | input | CH_W | Index of the channel being served |
| pin_in | input | 1 | Level seen on the pin, active low |
| pin_out | output | 1 | Level driven onto the pin, active low |
| pin_oe | output | 1 | Pin output enable |
| term_pulse | output | 1 | One-cycle request to stop the transfer |
| addr_float | output | 1 | Request to release the address bus |

## Verification
The assertions take for granted that `ch_busy` stays high for the whole life of a channel, and that `aen` only falls after any autoinitialize strobe. They also assume that `act_ch` and `ch_irq` change only on the rising edge, so that the falling-edge mirror reads settled values. The stimulus changes inputs a few nanoseconds after the rising edge. It raises the autoinitialize strobe at least one cycle before address enable drops, and it always ends a channel by lowering `ch_busy` rather than by changing the mode.

// File: rtl/eop_pkg.sv
package eop_pkg;

    typedef enum logic [1:0] {
        MODE_SENSE = 2'd0,
        MODE_TC    = 2'd1,
        MODE_IRQ   = 2'd2,
        MODE_QUIET = 2'd3
    } eop_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SENSE,
        ST_HALT,
        ST_TC_ARM,
        ST_TC_ON,
        ST_TC_REL,
        ST_IRQ
    } eop_state_e;

endpackage

// File: rtl/eop_pin_sampler.sv
module eop_pin_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic seen_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= ~pin_n_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], ~pin_n_i};
            end
        end
    endgenerate

    assign seen_o = chain_q[STAGES-1];
endmodule

// File: rtl/eop_irq_mirror.sv
module eop_irq_mirror #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_irq_i,
    input  logic [CH_W-1:0]   act_ch_i,
    output logic              irq_o
);
    logic sel_irq;
    logic irq_q;

    always_comb begin
        sel_irq = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (act_ch_i == CH_W'(i)) sel_irq = ch_irq_i[i];
        end
    end

    // updated on the falling edge so the pin follows half a cycle later
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= sel_irq;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/eop_mode_fsm.sv
module eop_mode_fsm
    import eop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  eop_mode_e mode_i,
    input  logic      busy_i,
    input  logic      aen_i,
    input  logic      addr_stb_i,
    input  logic      cnt_done_i,
    input  logic      autoinit_i,
    input  logic      seen_i,
    output logic      tc_drive_o,
    output logic      irq_path_o,
    output logic      listen_o,
    output logic      term_o,
    output logic      float_o
);
    eop_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!busy_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    case (mode_i)
                        MODE_SENSE: st_d = ST_SENSE;
                        MODE_TC:    st_d = ST_TC_ARM;
                        MODE_IRQ:   st_d = ST_IRQ;
                        default:    st_d = ST_IDLE;
                    endcase
                end
                ST_SENSE:  if (seen_i) st_d = ST_HALT;
                ST_HALT:   st_d = ST_HALT;
                ST_TC_ARM: if (addr_stb_i && cnt_done_i) st_d = ST_TC_ON;
                ST_TC_ON: begin
                    if (!aen_i)          st_d = ST_TC_ARM;
                    else if (autoinit_i) st_d = ST_TC_REL;
                end
                ST_TC_REL: if (!aen_i) st_d = ST_TC_ARM;
                ST_IRQ:    st_d = ST_IRQ;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        tc_drive_o = 1'b0;
        irq_path_o = 1'b0;
        listen_o   = 1'b0;
        term_o     = 1'b0;
        float_o    = 1'b0;
        unique case (st_q)
            ST_SENSE: begin
                listen_o = 1'b1;
                term_o   = seen_i;
                float_o  = seen_i;
            end
            ST_HALT: begin
                listen_o = 1'b1;
                float_o  = 1'b1;
            end
            ST_TC_ON: tc_drive_o = 1'b1;
            ST_IRQ:   irq_path_o = 1'b1;
            default: ;
        endcase
    end

    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && busy_i) |=> (st_q != ST_IDLE));

    p_term_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> !term_o);

    p_float_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && busy_i) |=> float_o);

    p_aen_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TC_ON && !aen_i) |=> !tc_drive_o);

    p_autoinit_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TC_ON && autoinit_i) |=> !tc_drive_o);
endmodule

// File: rtl/eop_pin_ctrl.sv
module eop_pin_ctrl
    import eop_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              ch_busy,
    input  logic              aen,
    input  logic              addr_stb,
    input  logic              cnt_done,
    input  logic              autoinit_stb,
    input  logic [NUM_CH-1:0] ch_irq,
    input  logic [CH_W-1:0]   act_ch,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              term_pulse,
    output logic              addr_float
);
    logic seen;
    logic irq_sel;
    logic tc_drive, irq_path, listen;

    eop_pin_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (pin_in),
        .seen_o  (seen)
    );

    eop_irq_mirror #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_mirror (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_irq_i (ch_irq),
        .act_ch_i (act_ch),
        .irq_o    (irq_sel)
    );

    eop_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (eop_mode_e'(mode_sel)),
        .busy_i     (ch_busy),
        .aen_i      (aen),
        .addr_stb_i (addr_stb),
        .cnt_done_i (cnt_done),
        .autoinit_i (autoinit_stb),
        .seen_i     (seen),
        .tc_drive_o (tc_drive),
        .irq_path_o (irq_path),
        .listen_o   (listen),
        .term_o     (term_pulse),
        .float_o    (addr_float)
    );

    assign pin_out = ~(tc_drive | (irq_path & irq_sel));
    assign pin_oe  = ~listen;

    p_idle_negated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_busy |=> (pin_out && pin_oe && !addr_float));

    p_term_listen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |-> !pin_oe);
endmodule

// File: tb/eop_pin_ctrl_test.sv
module eop_pin_ctrl_test;
    localparam int NV = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       ch_busy = 1'b0, aen = 1'b0, addr_stb = 1'b0, cnt_done = 1'b0;
    logic       autoinit_stb = 1'b0, pin_in = 1'b1;
    logic [7:0] ch_irq = 8'h00;
    logic [2:0] act_ch = 3'd0;
    logic       pin_out, pin_oe, term_pulse, addr_float;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eop_pin_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ch_busy(ch_busy),
        .aen(aen), .addr_stb(addr_stb), .cnt_done(cnt_done),
        .autoinit_stb(autoinit_stb), .ch_irq(ch_irq), .act_ch(act_ch),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .term_pulse(term_pulse), .addr_float(addr_float)
    );

    // {mode, busy aen stb cnt ai pin, ch, irq, exp pout oe term float}
    localparam logic [22:0] VECS [0:NV-1] = '{
        {2'd1, 6'b110001, 3'd0, 8'h00, 4'b1100},
        {2'd1, 6'b111001, 3'd0, 8'h00, 4'b1100},
        {2'd1, 6'b111101, 3'd0, 8'h00, 4'b0100},
        {2'd2, 6'b110000, 3'd0, 8'h00, 4'b0100},
        {2'd1, 6'b100000, 3'd0, 8'h00, 4'b1100},
        {2'd1, 6'b111101, 3'd0, 8'h00, 4'b0100},
        {2'd1, 6'b110011, 3'd0, 8'h00, 4'b1100},
        {2'd1, 6'b111101, 3'd0, 8'h00, 4'b1100},
        {2'd1, 6'b100001, 3'd0, 8'h00, 4'b1100},
        {2'd1, 6'b000001, 3'd0, 8'h00, 4'b1100},
        {2'd0, 6'b100001, 3'd0, 8'h00, 4'b1000},
        {2'd0, 6'b100000, 3'd0, 8'h00, 4'b1000},
        {2'd0, 6'b100000, 3'd0, 8'h00, 4'b1011},
        {2'd0, 6'b100000, 3'd0, 8'h00, 4'b1001},
        {2'd0, 6'b100001, 3'd0, 8'h00, 4'b1001},
        {2'd0, 6'b100000, 3'd0, 8'h00, 4'b1001},
        {2'd0, 6'b000001, 3'd0, 8'h00, 4'b1100},
        {2'd2, 6'b100001, 3'd3, 8'h00, 4'b1100},
        {2'd2, 6'b100001, 3'd3, 8'h08, 4'b0100},
        {2'd2, 6'b100001, 3'd3, 8'hF7, 4'b1100},
        {2'd2, 6'b100001, 3'd5, 8'h20, 4'b0100},
        {2'd2, 6'b000001, 3'd5, 8'h20, 4'b1100},
        {2'd3, 6'b100001, 3'd5, 8'h20, 4'b1100},
        {2'd0, 6'b000001, 3'd0, 8'h00, 4'b1100}
    };

    function automatic string req_of(int i);
        case (i)
            0, 1, 2, 5: return "R6";
            3, 22:      return "R3";
            4:          return "R12";
            6, 7:       return "R8";
            8:          return "R7";
            9, 16:      return "R11";
            10, 11:     return "R4";
            12, 13, 14, 15: return "R5";
            17, 18, 20: return "R9";
            19:         return "R10";
            default:    return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic apply(input logic [22:0] v);
        mode_sel     = v[22:21];
        ch_busy      = v[20];
        aen          = v[19];
        addr_stb     = v[18];
        cnt_done     = v[17];
        autoinit_stb = v[16];
        pin_in       = v[15];
        act_ch       = v[14:12];
        ch_irq       = v[11:4];
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(posedge clk);
        #3;
        chk("R1", "pin_out", pin_out, 1'b1);
        chk("R1", "pin_oe", pin_oe, 1'b1);
        chk("R1", "term_pulse", term_pulse, 1'b0);
        chk("R1", "addr_float", addr_float, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        chk("R1", "pin_out after release", pin_out, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(posedge clk);
            #3;
            chk(req_of(i), $sformatf("v%0d pin_out", i), pin_out, VECS[i][3]);
            chk(req_of(i), $sformatf("v%0d pin_oe", i), pin_oe, VECS[i][2]);
            chk(req_of(i), $sformatf("v%0d term_pulse", i), term_pulse, VECS[i][1]);
            chk(req_of(i), $sformatf("v%0d addr_float", i), addr_float, VECS[i][0]);
        end

        // R9: the mirror moves on the falling edge, not before
        mode_sel = 2'd2; ch_busy = 1'b1; act_ch = 3'd2; ch_irq = 8'h00;
        @(posedge clk);
        #3;
        ch_irq = 8'h04;
        #1;
        chk("R9", "pin_out before falling edge", pin_out, 1'b1);
        #3;
        chk("R9", "pin_out after falling edge", pin_out, 1'b0);
        ch_irq = 8'h00;
        #1;
        chk("R9", "pin_out held until next falling edge", pin_out, 1'b0);
        ch_busy = 1'b0;
        @(posedge clk);
        #3;

        // R1: reset while the count output is asserted
        mode_sel = 2'd1; ch_busy = 1'b1; aen = 1'b1; addr_stb = 1'b0; cnt_done = 1'b0;
        @(posedge clk);
        #3;
        addr_stb = 1'b1; cnt_done = 1'b1;
        @(posedge clk);
        #3;
        chk("R6", "pin_out asserted before reset", pin_out, 1'b0);
        addr_stb = 1'b0; cnt_done = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", "pin_out on async reset", pin_out, 1'b1);
        chk("R1", "pin_oe on async reset", pin_oe, 1'b1);
        ch_busy = 1'b0; aen = 1'b0;
        @(posedge clk);
        #3;
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        chk("R2", "pin_out idle after reset", pin_out, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule